// File: doc/BRIEF.md
# Stereo Envelope and Pan Mixer for Sign-Magnitude PCM Channels

This block is the mixing stage of an eight-channel PCM sound generator. A channel sequencer visits the channels in turn. In each channel's mixing slot it presents four things:

- the channel's current 8-bit sample, coded as sign and magnitude;
- its 8-bit envelope level;
- its packed pan byte;
- a one-cycle strobe.

The block turns the sample into a signed value and multiplies it by the envelope. It then scales the result once by the left pan nibble and once by the right pan nibble. Each side is divided by 32 with an arithmetic shift, and the result is added into a 16-bit signed accumulator for that side. Each addition saturates.

After the last channel of a frame, the sequencer raises a frame strobe. The two sums are then registered as one stereo output pair, marked by a one-cycle valid pulse, and both accumulators start again from zero. A separate clear input from the control path discards a partial frame at once, for example when sounding is switched off.

Contributions are added only while the global sounding flag is set and the visited channel is switched on. The sequencer supplies both of these qualifiers beside the strobe.

Top module: `pcm_stereo_mixer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` becomes 0, both outputs become 0 and both accumulators become 0. A frame emitted right after reset therefore reads 0 on both sides.
- R2: The sample magnitude is bits [6:0]. Bit 7 set to 1 makes the value positive, and bit 7 at 0 makes it negative. A magnitude of zero gives zero whatever the sign bit.
- R3: The signed sample value is multiplied by `env_in`, which is taken as an unsigned level from 0 to 255.
- R4: The left contribution is floor(scaled × `pan_in[7:4]` / 32) and the right contribution is floor(scaled × `pan_in[3:0]` / 32). The division is an arithmetic right shift by 5, so negative values round toward minus infinity.
- R5: A contribution is added at a clock edge only when `ch_valid`, `sounding` and `chan_on` are all 1 there. With any of them at 0, the sample, envelope and pan inputs do not change the sums.
- R6: When `frame_strobe` is 1 at an edge and `clear_mix` is 0, the outputs take the accumulated sums on that edge. The sums include any contribution qualified on the same edge. `out_valid` is 1 for exactly the following cycle, and both accumulators restart from 0.
- R7: `left_out` and `right_out` change only on an edge that raises `out_valid`. Between frames they hold their last value.
- R8: `clear_mix` set to 1 at an edge zeroes both accumulators and drops any contribution on that edge. If `frame_strobe` is also 1 on that edge, a pair of zeros is emitted.
- R9: Every addition saturates to the range -32768 to +32767 instead of wrapping. Later additions continue from the clamped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_valid | input | 1 | Mixing-slot strobe for the visited channel |
| sounding | input | 1 | Global sounding flag |
| chan_on | input | 1 | The visited channel is switched on |
| sample_in | input | 8 | Sample, sign and magnitude with bit 7 set meaning positive |
| env_in | input | 8 | Envelope level, unsigned |
| pan_in | input | 8 | Left gain in [7:4], right gain in [3:0] |
| clear_mix | input | 1 | Zero both accumulators now |
| frame_strobe | input | 1 | End of frame: emit the sums and restart |
| left_out | output | 16 | Left frame sum, two's complement |
| right_out | output | 16 | Right frame sum, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |

## Verification
The accumulators are visible only through the pair emitted at the next frame strobe. A wrong sign decode, a swapped pan nibble, a truncating shift or a missed gate therefore shows up as a wrong `left_out` or `right_out` one cycle after the frame strobe, and nothing shows before then. The saturation path shows only after several large same-signed additions within one frame. Reversing direction after clamping shows whether the accumulator resumed from the clamped value or from a wrapped one. The valid pulse and the hold behaviour are compared on every cycle, so a spurious or missing pulse is caught in the cycle it occurs.

// File: rtl/pcm_mix_pkg.sv
// Package: pcm_mix_pkg
// Shared defaults and the per-edge accumulator command used by the mixer.
// Assumes every user takes its widths from the top-level parameters.
package pcm_mix_pkg;

    localparam int DEF_SMP_W   = 8;
    localparam int DEF_ENV_W   = 8;
    localparam int DEF_GAIN_W  = 4;
    localparam int DEF_ACC_W   = 16;
    localparam int DEF_SHIFT   = 5;

    // What one side's accumulator does on a clock edge.
    typedef struct packed {
        logic add;      // fold the current contribution in
        logic clr;      // zero the running sum, drop the contribution
        logic emit;     // load the output register with the frame result
    } acc_cmd_t;

endpackage

// File: rtl/pcm_mix_ctrl.sv
// Module: pcm_mix_ctrl
// Decodes the sequencer qualifiers and frame controls into a single
// accumulator command shared by both sides, and registers the valid pulse.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module pcm_mix_ctrl
    import pcm_mix_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ch_valid,
    input  logic     sounding,
    input  logic     chan_on,
    input  logic     clear_mix,
    input  logic     frame_strobe,
    output acc_cmd_t cmd,
    output logic     out_valid
);

    // Build the command: clear overrides the add, emit follows the frame strobe.
    always_comb begin
        cmd.clr  = clear_mix;
        cmd.add  = ch_valid & sounding & chan_on & ~clear_mix;
        cmd.emit = frame_strobe;
    end

    // One-cycle valid pulse following each frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= frame_strobe;
        end
    end

endmodule

// File: rtl/pcm_mix_scale.sv
// Module: pcm_mix_scale
// Turns a sign-magnitude sample (top bit set = positive) into two's
// complement and multiplies it by an unsigned envelope level.
// Assumes SCALED_W holds the full product; the stage is purely combinational.
module pcm_mix_scale #(
    parameter int SMP_W = 8,
    parameter int ENV_W = 8,
    localparam int SCALED_W = SMP_W + ENV_W + 1
) (
    input  logic [SMP_W-1:0]           sample,
    input  logic [ENV_W-1:0]           env,
    output logic signed [SCALED_W-1:0] scaled
);

    logic [SMP_W-2:0]          mag;
    logic                      positive;
    logic signed [SMP_W-1:0]   signed_val;
    logic signed [SCALED_W-1:0] val_ext;
    logic signed [SCALED_W-1:0] env_ext;

    // Split the sample into its magnitude and its (inverted-sense) sign.
    always_comb begin
        mag      = sample[SMP_W-2:0];
        positive = sample[SMP_W-1];
    end

    // Apply the sign: a clear sign bit negates the magnitude.
    always_comb begin
        if (positive) begin
            signed_val = $signed({1'b0, mag});
        end else begin
            signed_val = -$signed({1'b0, mag});
        end
    end

    // Widen both factors and form the envelope-scaled value.
    always_comb begin
        val_ext = SCALED_W'(signed_val);
        env_ext = $signed(SCALED_W'({1'b0, env}));
        scaled  = val_ext * env_ext;
    end

endmodule

// File: rtl/pcm_mix_pan.sv
// Module: pcm_mix_pan
// Applies the two pan nibbles to the envelope-scaled value and divides each
// side by 2**SHIFT with an arithmetic shift (floor division).
// Assumes pan byte packs left gain in the upper nibble, right in the lower.
module pcm_mix_pan #(
    parameter int SCALED_W = 17,
    parameter int GAIN_W   = 4,
    parameter int SHIFT    = 5,
    localparam int PROD_W    = SCALED_W + GAIN_W + 1,
    localparam int CONTRIB_W = PROD_W - SHIFT
) (
    input  logic signed [SCALED_W-1:0]   scaled,
    input  logic [2*GAIN_W-1:0]          pan,
    output logic signed [CONTRIB_W-1:0]  contrib [2]
);

    // Side 0 is left (upper nibble), side 1 is right (lower nibble).
    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int LO = (s == 0) ? GAIN_W : 0;

        logic [GAIN_W-1:0]        gain;
        logic signed [PROD_W-1:0] val_ext;
        logic signed [PROD_W-1:0] gain_ext;
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] shifted;

        // Pick this side's nibble, multiply, then floor-divide by the shift.
        always_comb begin
            gain     = pan[LO +: GAIN_W];
            val_ext  = PROD_W'(scaled);
            gain_ext = $signed(PROD_W'({1'b0, gain}));
            prod     = val_ext * gain_ext;
            shifted  = prod >>> SHIFT;
            contrib[s] = shifted[CONTRIB_W-1:0];
        end
    end

endmodule

// File: rtl/pcm_mix_acc.sv
// Module: pcm_mix_acc
// One side's saturating frame accumulator plus its output holding register.
// Assumes the contribution is no wider than ACC_W + 1 bits after widening.
module pcm_mix_acc
    import pcm_mix_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int CONTRIB_W = 17,
    localparam int SUM_W    = ((ACC_W > CONTRIB_W) ? ACC_W : CONTRIB_W) + 1,
    localparam int TOP_W    = SUM_W - ACC_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  acc_cmd_t                     cmd,
    input  logic signed [CONTRIB_W-1:0]  contrib,
    output logic signed [ACC_W-1:0]      acc,
    output logic signed [ACC_W-1:0]      out_sum
);

    logic signed [SUM_W-1:0] raw_sum;
    logic [TOP_W-1:0]        top_bits;
    logic                    fits;
    logic signed [ACC_W-1:0] clamped;
    logic signed [ACC_W-1:0] next_sum;

    // Exact sum in a width that cannot overflow.
    always_comb begin
        raw_sum  = SUM_W'(acc) + SUM_W'(contrib);
        top_bits = raw_sum[SUM_W-1:ACC_W-1];
        fits     = (&top_bits) | ~(|top_bits);
    end

    // Clamp to the representable range when the upper bits disagree.
    always_comb begin
        if (fits) begin
            clamped = raw_sum[ACC_W-1:0];
        end else if (raw_sum[SUM_W-1]) begin
            clamped = {1'b1, {(ACC_W-1){1'b0}}};
        end else begin
            clamped = {1'b0, {(ACC_W-1){1'b1}}};
        end
    end

    // Select the running sum after this edge's optional addition.
    always_comb begin
        next_sum = cmd.add ? clamped : acc;
    end

    // Update the accumulator: clear wins, a frame restarts it, else keep summing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (cmd.clr || cmd.emit) begin
            acc <= '0;
        end else begin
            acc <= next_sum;
        end
    end

    // Load the output pair at a frame strobe; a simultaneous clear emits zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sum <= '0;
        end else if (cmd.emit) begin
            out_sum <= cmd.clr ? '0 : next_sum;
        end
    end

endmodule

// File: rtl/pcm_stereo_mixer.sv
// Module: pcm_stereo_mixer
// Top of the mixing stage: scales each qualified channel sample by envelope
// and pan, sums both sides over a frame with saturation, and emits the pair
// with a one-cycle valid pulse after each frame strobe.
// Assumes the sequencer drives one qualified strobe per channel mixing slot.
module pcm_stereo_mixer
    import pcm_mix_pkg::*;
#(
    parameter int SMP_W  = DEF_SMP_W,
    parameter int ENV_W  = DEF_ENV_W,
    parameter int GAIN_W = DEF_GAIN_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int SHIFT  = DEF_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ch_valid,
    input  logic                    sounding,
    input  logic                    chan_on,
    input  logic [SMP_W-1:0]        sample_in,
    input  logic [ENV_W-1:0]        env_in,
    input  logic [2*GAIN_W-1:0]     pan_in,
    input  logic                    clear_mix,
    input  logic                    frame_strobe,
    output logic signed [ACC_W-1:0] left_out,
    output logic signed [ACC_W-1:0] right_out,
    output logic                    out_valid
);

    localparam int SCALED_W  = SMP_W + ENV_W + 1;
    localparam int PROD_W    = SCALED_W + GAIN_W + 1;
    localparam int CONTRIB_W = PROD_W - SHIFT;

    acc_cmd_t                    cmd;
    logic signed [SCALED_W-1:0]  scaled;
    logic signed [CONTRIB_W-1:0] contrib [2];
    logic signed [ACC_W-1:0]     acc_side [2];
    logic signed [ACC_W-1:0]     out_side [2];

    pcm_mix_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_valid     (ch_valid),
        .sounding     (sounding),
        .chan_on      (chan_on),
        .clear_mix    (clear_mix),
        .frame_strobe (frame_strobe),
        .cmd          (cmd),
        .out_valid    (out_valid)
    );

    pcm_mix_scale #(
        .SMP_W (SMP_W),
        .ENV_W (ENV_W)
    ) u_scale (
        .sample (sample_in),
        .env    (env_in),
        .scaled (scaled)
    );

    pcm_mix_pan #(
        .SCALED_W (SCALED_W),
        .GAIN_W   (GAIN_W),
        .SHIFT    (SHIFT)
    ) u_pan (
        .scaled  (scaled),
        .pan     (pan_in),
        .contrib (contrib)
    );

    // One saturating accumulator per stereo side.
    for (genvar s = 0; s < 2; s++) begin : g_acc
        pcm_mix_acc #(
            .ACC_W     (ACC_W),
            .CONTRIB_W (CONTRIB_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .contrib (contrib[s]),
            .acc     (acc_side[s]),
            .out_sum (out_side[s])
        );
    end

    // Route the side registers to the named output ports.
    always_comb begin
        left_out  = out_side[0];
        right_out = out_side[1];
    end

endmodule

// File: rtl/pcm_mix_checker.sv
// Module: pcm_mix_checker
// Temporal properties of the mixer, attached to every instance by bind.
// Assumes the accumulator and contribution signals are wired in by the bind.
module pcm_mix_checker #(
    parameter int ACC_W     = 16,
    parameter int CONTRIB_W = 17
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ch_valid,
    input logic                        sounding,
    input logic                        chan_on,
    input logic                        clear_mix,
    input logic                        frame_strobe,
    input logic                        out_valid,
    input logic signed [ACC_W-1:0]     left_out,
    input logic signed [ACC_W-1:0]     right_out,
    input logic signed [ACC_W-1:0]     acc_l,
    input logic signed [ACC_W-1:0]     acc_r,
    input logic signed [CONTRIB_W-1:0] contrib_l,
    input logic signed [CONTRIB_W-1:0] contrib_r
);

    logic qual;
    logic plain_add;

    // Qualified addition with no clear or frame on the same edge.
    always_comb begin
        qual      = ch_valid & sounding & chan_on;
        plain_add = qual & ~clear_mix & ~frame_strobe;
    end

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> out_valid);

    p_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> !out_valid);

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> (acc_l == '0) && (acc_r == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(left_out) && $stable(right_out));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_mix |=> (acc_l == '0) && (acc_r == '0));

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && !clear_mix && !frame_strobe) |=> $stable(acc_l) && $stable(acc_r));

    p_no_wrap_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_add && acc_l >= 0 && contrib_l >= 0) |=> acc_l >= $past(acc_l));

    p_no_wrap_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_add && acc_l < 0 && contrib_l < 0) |=> acc_l <= $past(acc_l));

    p_no_wrap_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_add && acc_r >= 0 && contrib_r >= 0) |=> acc_r >= $past(acc_r));

endmodule

bind pcm_stereo_mixer pcm_mix_checker #(
    .ACC_W     (ACC_W),
    .CONTRIB_W (CONTRIB_W)
) u_mix_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_valid     (ch_valid),
    .sounding     (sounding),
    .chan_on      (chan_on),
    .clear_mix    (clear_mix),
    .frame_strobe (frame_strobe),
    .out_valid    (out_valid),
    .left_out     (left_out),
    .right_out    (right_out),
    .acc_l        (acc_side[0]),
    .acc_r        (acc_side[1]),
    .contrib_l    (contrib[0]),
    .contrib_r    (contrib[1])
);

// File: tb/tb_pcm_stereo_mixer.sv
// Bench: behavioural integer model updated on each rising edge, compared with
// the outputs on every falling edge. Inputs change only on falling edges.
module tb_pcm_stereo_mixer;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ch_valid = 1'b0;
    logic              sounding = 1'b0;
    logic              chan_on = 1'b0;
    logic [7:0]        sample_in = 8'h00;
    logic [7:0]        env_in = 8'h00;
    logic [7:0]        pan_in = 8'h00;
    logic              clear_mix = 1'b0;
    logic              frame_strobe = 1'b0;
    logic signed [15:0] left_out;
    logic signed [15:0] right_out;
    logic              out_valid;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string tag = "R1";

    int m_acc_l = 0, m_acc_r = 0, m_out_l = 0, m_out_r = 0;
    bit m_val = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pcm_stereo_mixer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_valid     (ch_valid),
        .sounding     (sounding),
        .chan_on      (chan_on),
        .sample_in    (sample_in),
        .env_in       (env_in),
        .pan_in       (pan_in),
        .clear_mix    (clear_mix),
        .frame_strobe (frame_strobe),
        .left_out     (left_out),
        .right_out    (right_out),
        .out_valid    (out_valid)
    );

    function automatic int side_val(input logic [7:0] s, input logic [7:0] e,
                                    input logic [3:0] g);
        int v;
        v = int'(s[6:0]);
        if (!s[7]) v = -v;
        v = v * int'(e) * int'(g);
        return v >>> 5;   // floor division by 32
    endfunction

    function automatic int clamp16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Reference model: mirrors the requirements, one update per edge.
    always @(posedge clk) begin
        int nl, nr;
        if (!rst_n) begin
            m_acc_l = 0; m_acc_r = 0; m_out_l = 0; m_out_r = 0; m_val = 1'b0;
        end else begin
            nl = m_acc_l; nr = m_acc_r;
            if (ch_valid && sounding && chan_on && !clear_mix) begin
                nl = clamp16(m_acc_l + side_val(sample_in, env_in, pan_in[7:4]));
                nr = clamp16(m_acc_r + side_val(sample_in, env_in, pan_in[3:0]));
            end
            m_val = frame_strobe;
            if (clear_mix) begin
                m_acc_l = 0; m_acc_r = 0;
                if (frame_strobe) begin m_out_l = 0; m_out_r = 0; end
            end else if (frame_strobe) begin
                m_out_l = nl; m_out_r = nr; m_acc_l = 0; m_acc_r = 0;
            end else begin
                m_acc_l = nl; m_acc_r = nr;
            end
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (out_valid !== m_val || int'(left_out) != m_out_l ||
                int'(right_out) != m_out_r || $isunknown({left_out, right_out})) begin
                n_bad++;
                $display("FAIL %s: got valid=%0b L=%0d R=%0d, expected valid=%0b L=%0d R=%0d",
                         tag, out_valid, left_out, right_out, m_val, m_out_l, m_out_r);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic step(input bit v, input bit snd, input bit on,
                        input logic [7:0] s, input logic [7:0] e, input logic [7:0] p,
                        input bit clr, input bit frm);
        @(negedge clk);
        ch_valid = v; sounding = snd; chan_on = on;
        sample_in = s; env_in = e; pan_in = p;
        clear_mix = clr; frame_strobe = frm;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 1, 8'h00, 8'h00, 8'h00, 0, 0);
    endtask

    task automatic add(input logic [7:0] s, input logic [7:0] e, input logic [7:0] p);
        step(1, 1, 1, s, e, p, 0, 0);
    endtask

    task automatic frame();
        step(0, 1, 1, 8'h00, 8'h00, 8'h00, 0, 1);
        idle(2);
    endtask

    initial begin
        // R1: reset state, then an immediate frame reads zero.
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        frame();

        // R2: sign decoding, positive / negative / zero magnitudes.
        tag = "R2";
        add(8'h85, 8'h40, 8'hF3); frame();
        add(8'h05, 8'h40, 8'hF3); frame();
        add(8'h00, 8'hFF, 8'hFF); add(8'h80, 8'hFF, 8'hFF); frame();

        // R3: envelope levels including 0 and full scale.
        tag = "R3";
        add(8'hC0, 8'h00, 8'hFF); frame();
        add(8'hC0, 8'hFF, 8'h88); frame();
        add(8'h40, 8'h13, 8'h88); frame();

        // R4: separate nibbles and floor rounding on negatives.
        tag = "R4";
        add(8'h01, 8'h01, 8'h11); frame();
        add(8'h8A, 8'h21, 8'hF0); frame();
        add(8'h0A, 8'h21, 8'h0F); frame();
        add(8'h33, 8'h07, 8'h5C); frame();

        // R5: each qualifier low blocks the addition.
        tag = "R5";
        add(8'h90, 8'h80, 8'h77);
        step(1, 0, 1, 8'hFF, 8'hFF, 8'hFF, 0, 0);
        step(1, 1, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0);
        step(0, 1, 1, 8'hFF, 8'hFF, 8'hFF, 0, 0);
        frame();

        // R6: eight channels, last one qualified on the frame edge; back-to-back frames.
        tag = "R6";
        for (int c = 0; c < 7; c++) add(8'(8'h81 + 8'(c * 9)), 8'(8'h20 + 8'(c)), 8'(8'h1F + 8'(c * 16)));
        step(1, 1, 1, 8'h23, 8'hE0, 8'hA6, 0, 1);
        step(1, 1, 1, 8'hF0, 8'h30, 8'h99, 0, 1);
        step(0, 1, 1, 8'h00, 8'h00, 8'h00, 0, 1);
        idle(2);

        // R7: outputs hold through a long idle stretch.
        tag = "R7";
        add(8'hAA, 8'h55, 8'h3C);
        idle(20);
        frame();

        // R8: clear drops partial frame and same-edge contribution; clear with frame emits zero.
        tag = "R8";
        add(8'hFF, 8'hFF, 8'hFF);
        step(1, 1, 1, 8'hFF, 8'hFF, 8'hFF, 1, 0);
        add(8'h82, 8'h10, 8'h21);
        frame();
        add(8'hFF, 8'hFF, 8'hFF);
        step(1, 1, 1, 8'hFF, 8'hFF, 8'hFF, 1, 1);
        idle(2);

        // R9: positive clamp then descent, and negative clamp.
        tag = "R9";
        for (int i = 0; i < 4; i++) add(8'hFF, 8'hFF, 8'hFF);
        add(8'h7F, 8'hFF, 8'hFF);
        frame();
        for (int i = 0; i < 4; i++) add(8'h7F, 8'hFF, 8'hFF);
        add(8'hFF, 8'hFF, 8'h8F);
        frame();

        // R2, R4, R5, R9 mixed: pseudo-random traffic.
        tag = "R5_mix";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step(r < 80, r != 3, r != 4, 8'($urandom), 8'($urandom), 8'($urandom),
                 r == 5, (i % 9) == 8);
        end
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule